// File: doc/BRIEF.md
# Timed EEPROM Control Unit

This unit fronts a small byte-wide non-volatile store with four byte registers on a simple register bus: control, data, address low and address high. A read is started by a strobe bit in the control register. It copies the addressed byte into the data register and holds the processor stall line for a fixed number of cycles. A location that has never been programmed returns 0xFF.

Programming takes two steps. Setting the arm bit opens a short window. Setting the program bit while that window is still open latches the address and data and sets the busy flag for a long, parameterised number of clock cycles. The byte lands in the store when that count completes. A program request made while busy is dropped. Register writes made while busy change the registers but not the byte being programmed.

A level-style ready interrupt is raised while the unit is idle and the ready-interrupt enable is set. It is raised by the completion of a write or by enabling the interrupt while idle. A read strobe withdraws it. The interrupt comes with a fixed vector output.

Top module: `eeprom_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, `irq` and `cpu_stall` are low and no write is in progress.
- R2: Writing control bit 2 (arm) sets it. It reads back set for UNLOCK_WIN clock edges and then clears by itself.
- R3: Writing control bit 1 (program) while armed and idle latches the address and data and sets busy (control bit 1). Busy reads 1 for exactly WRITE_CYCLES cycles, and the byte is then stored.
- R4: A program request made when the arm window has expired, or was never opened, stores nothing, and the program/busy bit reads 0.
- R5: A program request issued while busy is ignored entirely. The busy end time is unchanged and its address and data are never stored.
- R6: Writes to the data or address registers during busy are accepted but do not alter the byte or location being programmed.
- R7: Writing control bit 0 (read strobe) loads the byte at the 16-bit address formed from the high and low registers into the data register, and holds `cpu_stall` high for READ_STALL cycles.
- R8: Starting a write holds `cpu_stall` high for WRITE_STALL cycles.
- R9: Unprogrammed locations read as 0xFF.
- R10: `irq` follows control bit 3 (ready enable). It rises on write completion while enabled, rises when the enable is written 1 while idle, falls when the enable is written 0, and is never high while busy.
- R11: A read strobe withdraws a pending ready interrupt, even while the enable stays set.
- R12: `irq_vector` is constant 0x2C.
- R13: The strobe bit (bit 0) always reads 0. Addresses wrap modulo the store depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 data, 2 address low, 3 address high |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read-back of the selected register |
| cpu_stall | output | 1 | Processor stall request |
| irq | output | 1 | Ready interrupt request, level |
| irq_vector | output | 8 | Ready interrupt vector |

## Verification
Program requests are issued at arm-to-program gaps of zero, three and four idle cycles, and with no arm at all. The three-cycle gap must succeed and the four-cycle gap must fail, which pins down the window edge. A second arm-and-program sequence, together with fresh data and address writes, is issued in the middle of a write. This shows whether the first latched values survive and whether the busy period is extended or restarted. The interrupt is driven by completion, by enabling it while idle, by disabling it and by a read strobe, which separates the level condition from the withdrawal rule. An address above the store depth checks the wrap-around.

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl #(
  parameter int ADDR_W       = 8,
  parameter int WRITE_CYCLES = 680000,
  parameter int UNLOCK_WIN   = 4,
  parameter int READ_STALL   = 4,
  parameter int WRITE_STALL  = 2,
  parameter logic [7:0] READY_VECTOR = 8'h2C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       cpu_stall,
  output logic       irq,
  output logic [7:0] irq_vector
);
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int WC_W      = $clog2(WRITE_CYCLES + 1);
  localparam int MW_W      = $clog2(UNLOCK_WIN + 1);
  localparam int STALL_MAX = (READ_STALL > WRITE_STALL) ? READ_STALL : WRITE_STALL;
  localparam int ST_W      = $clog2(STALL_MAX + 1);

  logic [7:0]        mem [DEPTH];
  logic [7:0]        data_q, addr_lo_q, addr_hi_q, wdata_lat;
  logic [ADDR_W-1:0] waddr_lat;
  logic [WC_W-1:0]   wcnt;
  logic [MW_W-1:0]   mwin;
  logic [ST_W-1:0]   stall_cnt;
  logic              rie, pend;

  wire ctrl_wr = reg_wr && (reg_sel == 2'd0);
  wire busy    = (wcnt != '0);
  wire armed   = (mwin != '0);
  wire rd_go   = ctrl_wr && reg_wdata[0];
  wire wr_go   = ctrl_wr && reg_wdata[1] && armed && !busy;
  wire done    = (wcnt == WC_W'(1));
  wire [ADDR_W-1:0] cur_addr = ADDR_W'({addr_hi_q, addr_lo_q});

  assign cpu_stall  = (stall_cnt != '0);
  assign irq        = pend;
  assign irq_vector = READY_VECTOR;

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {4'b0, rie, armed, busy, 1'b0};
      2'd1:    reg_rdata = data_q;
      2'd2:    reg_rdata = addr_lo_q;
      default: reg_rdata = addr_hi_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q    <= '0;
      addr_lo_q <= '0;
      addr_hi_q <= '0;
      rie       <= 1'b0;
    end else begin
      if (reg_wr && reg_sel == 2'd1) data_q <= reg_wdata;
      if (reg_wr && reg_sel == 2'd2) addr_lo_q <= reg_wdata;
      if (reg_wr && reg_sel == 2'd3) addr_hi_q <= reg_wdata;
      if (ctrl_wr) rie <= reg_wdata[3];
      if (rd_go) data_q <= mem[cur_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mwin <= '0;
    end else if (wr_go) begin
      mwin <= '0;
    end else if (ctrl_wr && reg_wdata[2]) begin
      mwin <= MW_W'(UNLOCK_WIN);
    end else if (armed) begin
      mwin <= mwin - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt      <= '0;
      waddr_lat <= '0;
      wdata_lat <= '0;
    end else if (wr_go) begin
      wcnt      <= WC_W'(WRITE_CYCLES);
      waddr_lat <= cur_addr;
      wdata_lat <= data_q;
    end else if (busy) begin
      wcnt <= wcnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (done) begin
      mem[waddr_lat] <= wdata_lat;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      stall_cnt <= '0;
    else if (wr_go)
      stall_cnt <= ST_W'(WRITE_STALL);
    else if (rd_go)
      stall_cnt <= ST_W'(READ_STALL);
    else if (cpu_stall)
      stall_cnt <= stall_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pend <= 1'b0;
    else if (rd_go || wr_go || (ctrl_wr && !reg_wdata[3]))
      pend <= 1'b0;
    else if (ctrl_wr && reg_wdata[3] && !busy)
      pend <= 1'b1;
    else if (done && rie)
      pend <= 1'b1;
  end

  a_r3_busy_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctrl_wr && reg_wdata[1]));
  a_r4_no_start_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && reg_wdata[1] && !armed && !busy) |=> !busy);
  a_r6_latch_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(waddr_lat) && $stable(wdata_lat)));
  a_r8_stall_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cpu_stall);
  a_r10_irq_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && rie));
endmodule

// File: tb/test_eeprom_ctrl.sv
`timescale 1ns/1ps
module test_eeprom_ctrl;
  localparam int WC = 40;
  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata, irq_vector;
  logic cpu_stall, irq;
  int checks = 0, errors = 0, cyc = 0, s = 0;
  bit done_flag = 0;

  eeprom_ctrl #(.WRITE_CYCLES(WC)) i_eeprom_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_stall(cpu_stall),
    .irq(irq), .irq_vector(irq_vector));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  localparam logic [7:0] RD = 8'h01, PE = 8'h02, ME = 8'h04, RIE = 8'h08;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] v);
    reg_sel = sel; #1; v = reg_rdata;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic read_byte(input logic [15:0] a, output logic [7:0] v);
    wr(2, a[7:0]); wr(3, a[15:8]); wr(0, RD);
    rd(1, v);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(0, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h0);
    chk("R1 stall", {7'b0, cpu_stall}, 8'h0);
    chk("R12 vector", irq_vector, 8'h2C);
    wr(2, 8'h10); wr(3, 8'h00); wr(0, RD); s = cyc;
    rd(1, v); chk("R9 erased", v, 8'hFF);
    rd(0, v); chk("R13 strobe reads 0", v, 8'h00);
    chk("R7 stall start", {7'b0, cpu_stall}, 8'h1);
    wait_to(s + 3); chk("R7 stall last", {7'b0, cpu_stall}, 8'h1);
    wait_to(s + 4); chk("R7 stall end", {7'b0, cpu_stall}, 8'h0);
  endtask

  task automatic t_window;
    logic [7:0] v;
    wr(0, ME); s = cyc;
    rd(0, v); chk("R2 armed", v, ME);
    wait_to(s + 3); rd(0, v); chk("R2 still armed", v, ME);
    wait_to(s + 4); rd(0, v); chk("R2 expired", v, 8'h00);
  endtask

  task automatic t_write;
    logic [7:0] v;
    wr(1, 8'h11); wr(2, 8'h05); wr(3, 8'h00);
    wr(0, ME);
    repeat (3) @(negedge clk);
    wr(0, PE); s = cyc;
    rd(0, v); chk("R3 busy set", v, PE);
    chk("R8 stall 0", {7'b0, cpu_stall}, 8'h1);
    wr(0, RIE);
    chk("R8 stall 1", {7'b0, cpu_stall}, 8'h1);
    chk("R10 no irq while busy", {7'b0, irq}, 8'h0);
    wr(1, 8'h99);
    chk("R8 stall done", {7'b0, cpu_stall}, 8'h0);
    wr(2, 8'h06);
    wr(0, RIE | ME);
    wr(0, RIE | PE);
    wait_to(s + WC - 1);
    rd(0, v); chk("R5 busy end unchanged (still busy)", v & PE, PE);
    chk("R10 irq low busy", {7'b0, irq}, 8'h0);
    wait_to(s + WC);
    rd(0, v); chk("R3 busy cleared", v & PE, 8'h00);
    chk("R10 irq on completion", {7'b0, irq}, 8'h1);
    wr(0, RIE | RD);
    chk("R11 withdrawn", {7'b0, irq}, 8'h0);
    @(negedge clk);
    chk("R11 stays withdrawn", {7'b0, irq}, 8'h0);
    wr(0, RIE); chk("R10 enable while idle", {7'b0, irq}, 8'h1);
    wr(0, 8'h00); chk("R10 disable", {7'b0, irq}, 8'h0);
    read_byte(16'h0005, v); chk("R3 stored byte", v, 8'h11);
    read_byte(16'h0006, v); chk("R5 R6 second not stored", v, 8'hFF);
    read_byte(16'h0105, v); chk("R13 address wrap", v, 8'h11);
  endtask

  task automatic t_reject;
    logic [7:0] v;
    wr(1, 8'h33); wr(2, 8'h07); wr(3, 8'h00);
    wr(0, ME);
    repeat (4) @(negedge clk);
    wr(0, PE);
    rd(0, v); chk("R4 late program reads 0", v, 8'h00);
    wr(0, PE);
    rd(0, v); chk("R4 unarmed program reads 0", v, 8'h00);
    repeat (WC + 5) @(negedge clk);
    read_byte(16'h0007, v); chk("R4 nothing stored", v, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_window;
    t_write;
    t_reject;
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule